// File: doc/BRIEF.md
# Token-Gated Dictionary Automaton

This block is a byte-serial deterministic automaton for whole-token dictionary matching. It consumes one 8-bit character on every clock. A separate boundary detector supplies a start pulse on a token's first character and an end pulse on its last. The automaton stays in its idle state (state 0) outside tokens. It may leave idle only on a start pulse, and it is pulled back to idle on every end pulse, whatever its computed next state. A pattern is therefore reported only when it covers the whole token.

Two small rule tables set the next state. A transition table is keyed by current state and character and holds the forward edges. A default table is keyed by character alone and holds the fallback links used when a partial pattern fails. A third table gives each state a match identifier, where 0 means "not accepting". Software fills all three through one write port, which takes effect only while no token is in progress.

Top module: `tgd_matcher`

## Requirements
- R1: After reset, `match_valid` is 0, `match_id` is 0, the state is idle and every rule and identifier entry is empty, so a token gives no match before any write.
- R2: While no token is in progress and `tok_start` is low, the state stays idle whatever the characters are, and a lone `tok_end` outside a token gives no match.
- R3: The state leaves idle only in a cycle with `tok_start` high, and the step uses that cycle's character.
- R4: Inside a token, the state advances on every character with no further control input.
- R5: A transition entry matching the current state and character wins over any default entry. Among matching transition entries, the lowest index wins.
- R6: When no transition entry matches, a default entry matching the character gives the next state. Among matching default entries, the lowest index wins.
- R7: When neither table matches, the next state is idle.
- R8: With `tok_end` high, the registered state returns to idle and the token ends. A following token starts from idle.
- R9: In the cycle after a `tok_end` cycle inside a token, `match_valid` pulses for one cycle with `match_id` equal to the identifier of the state reached on the `tok_end` character, but only if that identifier is non-zero. At all other times `match_valid` is 0 and `match_id` is 0.
- R10: A token whose last character leads to a state with identifier 0 gives no match, even when an accepting state was passed earlier in the token.
- R11: `cfg_tbl` selects the target table: 0 is the transition entry `cfg_idx`, 1 is the default entry `cfg_idx` (ignored when `cfg_idx` ≥ DEF_N), 2 is the identifier of state `cfg_state`, and 3 writes nothing. A write counts only when no token is in progress and `tok_start` is low; otherwise it is ignored.
- R12: A `tok_start` inside a token restarts the lookup from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr | input | 8 | Character for this cycle |
| tok_start | input | 1 | First character of a token |
| tok_end | input | 1 | Last character of a token |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 2 | Table select |
| cfg_idx | input | IDX_W | Rule entry index |
| cfg_on | input | 1 | Entry enable bit written with the rule |
| cfg_state | input | STATE_W | Rule source state / identifier target state |
| cfg_char | input | 8 | Rule character |
| cfg_next | input | STATE_W | Rule destination state |
| cfg_id | input | ID_W | Match identifier written to a state |
| match_valid | output | 1 | One-cycle match pulse |
| match_id | output | ID_W | Identifier of the matched pattern |

## Verification
The bench uses the default parameters: 16 states, 16 transition entries, 8 default entries and 8-bit identifiers. With these values it can place duplicate keys in both tables to check index priority, write beyond the default table's range, and build a small dictionary with overlapping patterns ("b", "ab", "abc"). A behavioural model compares both outputs on every clock, through directed tokens and a long pseudo-random stream of characters and boundary pulses.

// File: rtl/tgd_pkg.sv
package tgd_pkg;
    typedef enum logic [1:0] {
        TBL_TRANS   = 2'd0,
        TBL_DEFAULT = 2'd1,
        TBL_ACCEPT  = 2'd2,
        TBL_NONE    = 2'd3
    } tbl_sel_e;
endpackage

// File: rtl/tgd_rule_table.sv
module tgd_rule_table #(
    parameter int N         = 16,
    parameter int SW        = 4,
    parameter int CW        = 8,
    parameter bit KEY_STATE = 1'b1,
    localparam int IW       = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_on,
    input  logic [SW-1:0] wr_state,
    input  logic [CW-1:0] wr_char,
    input  logic [SW-1:0] wr_next,
    input  logic [SW-1:0] lk_state,
    input  logic [CW-1:0] lk_char,
    output logic          hit,
    output logic [SW-1:0] hit_next
);
    typedef struct packed {
        logic [N-1:0]         on;
        logic [N-1:0][SW-1:0] st;
        logic [N-1:0][CW-1:0] ch;
        logic [N-1:0][SW-1:0] nx;
    } tbl_t;

    tbl_t         tbl_d, tbl_q;
    logic [N-1:0] hit_vec;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.on[wr_idx] = wr_on;
            tbl_d.st[wr_idx] = wr_state;
            tbl_d.ch[wr_idx] = wr_char;
            tbl_d.nx[wr_idx] = wr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        if (KEY_STATE) begin : g_keyed
            assign hit_vec[g] = tbl_q.on[g] && (tbl_q.ch[g] == lk_char)
                                && (tbl_q.st[g] == lk_state);
        end else begin : g_char_only
            assign hit_vec[g] = tbl_q.on[g] && (tbl_q.ch[g] == lk_char)
                                && (lk_state == lk_state);
        end
    end

    // lowest index wins: scan downward so the smallest match is assigned last
    always_comb begin
        hit_next = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_next = tbl_q.nx[i];
        end
    end

    assign hit = |hit_vec;

    // R11: contents change only through an accepted write
    a_r11_rules_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));

    // R1: the table is empty in the cycle after reset
    a_r1_rules_empty: assert property (@(posedge clk)
        !rst_n |=> (tbl_q.on == '0));
endmodule

// File: rtl/tgd_accept_ids.sv
module tgd_accept_ids #(
    parameter int SW  = 4,
    parameter int IW  = 8,
    localparam int NS = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_state,
    input  logic [IW-1:0] wr_id,
    input  logic [SW-1:0] rd_state,
    output logic [IW-1:0] rd_id
);
    typedef struct packed {
        logic [NS-1:0][IW-1:0] id;
    } ids_t;

    ids_t ids_d, ids_q;

    always_comb begin
        ids_d = ids_q;
        if (wr_en) ids_d.id[wr_state] = wr_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ids_q <= '0;
        else        ids_q <= ids_d;
    end

    assign rd_id = ids_q.id[rd_state];

    // R11: identifiers change only through an accepted write
    a_r11_ids_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ids_q));
endmodule

// File: rtl/tgd_matcher.sv
module tgd_matcher
    import tgd_pkg::*;
#(
    parameter int STATE_W  = 4,
    parameter int TRANS_N  = 16,
    parameter int DEF_N    = 8,
    parameter int ID_W     = 8,
    localparam int TIW     = $clog2(TRANS_N),
    localparam int DIW     = $clog2(DEF_N),
    localparam int IDX_W   = (TIW > DIW) ? TIW : DIW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         chr,
    input  logic               tok_start,
    input  logic               tok_end,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_tbl,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_on,
    input  logic [STATE_W-1:0] cfg_state,
    input  logic [7:0]         cfg_char,
    input  logic [STATE_W-1:0] cfg_next,
    input  logic [ID_W-1:0]    cfg_id,
    output logic               match_valid,
    output logic [ID_W-1:0]    match_id
);
    localparam logic [STATE_W-1:0] IDLE = '0;

    typedef struct packed {
        logic [STATE_W-1:0] st;
        logic               in_tok;
        logic               mv;
        logic [ID_W-1:0]    mid;
    } core_t;

    core_t              core_d, core_q;
    logic               active, wr_ok;
    logic               tr_we, df_we, ac_we;
    logic [STATE_W-1:0] cur_st, step_st;
    logic               tr_hit, df_hit;
    logic [STATE_W-1:0] tr_next, df_next;
    logic [ID_W-1:0]    step_id;
    tbl_sel_e           sel;

    // ---------------- table writes (only while idle between tokens)
    assign sel   = tbl_sel_e'(cfg_tbl);
    assign wr_ok = cfg_we && !core_q.in_tok && !tok_start;
    assign tr_we = wr_ok && (sel == TBL_TRANS) && (32'(cfg_idx) < TRANS_N);
    assign df_we = wr_ok && (sel == TBL_DEFAULT) && (32'(cfg_idx) < DEF_N);
    assign ac_we = wr_ok && (sel == TBL_ACCEPT);

    // ---------------- lookup
    assign active = tok_start || core_q.in_tok;
    assign cur_st = tok_start ? IDLE : core_q.st;

    tgd_rule_table #(
        .N(TRANS_N), .SW(STATE_W), .CW(8), .KEY_STATE(1'b1)
    ) u_trans (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tr_we), .wr_idx(cfg_idx[TIW-1:0]), .wr_on(cfg_on),
        .wr_state(cfg_state), .wr_char(cfg_char), .wr_next(cfg_next),
        .lk_state(cur_st), .lk_char(chr),
        .hit(tr_hit), .hit_next(tr_next)
    );

    tgd_rule_table #(
        .N(DEF_N), .SW(STATE_W), .CW(8), .KEY_STATE(1'b0)
    ) u_default (
        .clk(clk), .rst_n(rst_n),
        .wr_en(df_we), .wr_idx(cfg_idx[DIW-1:0]), .wr_on(cfg_on),
        .wr_state(cfg_state), .wr_char(cfg_char), .wr_next(cfg_next),
        .lk_state(cur_st), .lk_char(chr),
        .hit(df_hit), .hit_next(df_next)
    );

    // state-and-character edge first, then the character-only fallback
    always_comb begin
        if (tr_hit)      step_st = tr_next;
        else if (df_hit) step_st = df_next;
        else             step_st = IDLE;
    end

    tgd_accept_ids #(
        .SW(STATE_W), .IW(ID_W)
    ) u_ids (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ac_we), .wr_state(cfg_state), .wr_id(cfg_id),
        .rd_state(step_st), .rd_id(step_id)
    );

    // ---------------- next-state
    always_comb begin
        core_d     = core_q;
        core_d.mv  = 1'b0;
        core_d.mid = '0;
        if (active) begin
            if (tok_end) begin
                core_d.st     = IDLE;
                core_d.in_tok = 1'b0;
                if (step_id != '0) begin
                    core_d.mv  = 1'b1;
                    core_d.mid = step_id;
                end
            end else begin
                core_d.st     = step_st;
                core_d.in_tok = 1'b1;
            end
        end else begin
            core_d.st = IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign match_valid = core_q.mv;
    assign match_id    = core_q.mid;

    // ---------------- assertions
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_start && !core_q.in_tok) |=> (core_q.st == IDLE));

    a_r8_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tok_end |=> (core_q.st == IDLE && !core_q.in_tok));

    a_r9_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(tok_end));

    a_r9_id_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> (match_id != '0));

    a_r9_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> (match_id == '0));

    a_r11_no_write_in_token: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.in_tok |-> !(tr_we || df_we || ac_we));
endmodule

// File: tb/tgd_matcher_test.sv
`timescale 1ns/1ps
module tgd_matcher_test;
    localparam int SW = 4, TN = 16, DN = 8, IW = 8, XW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    chr = '0;
    logic          tok_start = 1'b0, tok_end = 1'b0;
    logic          cfg_we = 1'b0, cfg_on = 1'b0;
    logic [1:0]    cfg_tbl = '0;
    logic [XW-1:0] cfg_idx = '0;
    logic [SW-1:0] cfg_state = '0, cfg_next = '0;
    logic [7:0]    cfg_char = '0;
    logic [IW-1:0] cfg_id = '0;
    logic          match_valid;
    logic [IW-1:0] match_id;

    always #4 clk = ~clk;

    tgd_matcher #(.STATE_W(SW), .TRANS_N(TN), .DEF_N(DN), .ID_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .chr(chr), .tok_start(tok_start), .tok_end(tok_end),
        .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx), .cfg_on(cfg_on),
        .cfg_state(cfg_state), .cfg_char(cfg_char), .cfg_next(cfg_next), .cfg_id(cfg_id),
        .match_valid(match_valid), .match_id(match_id)
    );

    // behavioural reference
    bit       tr_on [TN];  int tr_st [TN]; int tr_ch [TN]; int tr_nx [TN];
    bit       df_on [DN];  int df_ch [DN]; int df_nx [DN];
    int       acc [16];
    int       m_st = 0;    bit m_in = 0;
    bit       exp_v = 0;   int exp_id = 0;
    int       vectors = 0, fails = 0;

    task automatic model(input int c, input bit s, input bit e);
        int  cur, nxt;
        bit  found, was_in;
        was_in = m_in;
        cur = s ? 0 : m_st;
        nxt = 0; found = 0;
        for (int i = 0; i < TN; i++)
            if (!found && tr_on[i] && tr_st[i] == cur && tr_ch[i] == c) begin nxt = tr_nx[i]; found = 1; end
        for (int i = 0; i < DN; i++)
            if (!found && df_on[i] && df_ch[i] == c) begin nxt = df_nx[i]; found = 1; end
        exp_v = 0; exp_id = 0;
        if (s || m_in) begin
            if (e) begin
                if (acc[nxt] != 0) begin exp_v = 1; exp_id = acc[nxt]; end
                m_st = 0; m_in = 0;
            end else begin
                m_st = nxt; m_in = 1;
            end
        end else m_st = 0;
        if (cfg_we && !was_in && !s) begin
            case (cfg_tbl)
                2'd0: begin tr_on[cfg_idx] = cfg_on; tr_st[cfg_idx] = cfg_state;
                            tr_ch[cfg_idx] = cfg_char; tr_nx[cfg_idx] = cfg_next; end
                2'd1: if (cfg_idx < DN) begin df_on[cfg_idx] = cfg_on;
                            df_ch[cfg_idx] = cfg_char; df_nx[cfg_idx] = cfg_next; end
                2'd2: acc[cfg_state] = cfg_id;
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic [7:0] c, input bit s, input bit e, input string req);
        chr = c; tok_start = s; tok_end = e;
        model(c, s, e);
        @(posedge clk); @(negedge clk);
        vectors++;
        if (match_valid !== exp_v || match_id !== exp_id[IW-1:0]) begin
            fails++;
            $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     req, match_valid, match_id, exp_v, exp_id);
        end
        chr = '0; tok_start = 0; tok_end = 0; cfg_we = 0;
    endtask

    task automatic wr(input int tbl, input int idx, input bit on, input int st,
                      input byte ch, input int nx, input int id, input string req);
        cfg_we = 1; cfg_tbl = 2'(tbl); cfg_idx = XW'(idx); cfg_on = on;
        cfg_state = SW'(st); cfg_char = ch; cfg_next = SW'(nx); cfg_id = IW'(id);
        step(8'h20, 0, 0, req);
    endtask

    // a token, then one idle cycle in which the match pulse is compared
    task automatic tok(input string t, input string req);
        for (int i = 0; i < t.len(); i++)
            step(t[i], i == 0, i == t.len() - 1, req);
        step(8'h20, 0, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4: watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) acc[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(8'h20, 0, 0, "R1");
        tok("ab", "R1");                       // empty tables: no match

        // dictionary: b->3, ab->5, abc->7 (states 4, 2, 3)
        wr(1, 0, 1, 0, "a", 1, 0, "R11");
        wr(1, 1, 1, 0, "b", 4, 0, "R11");
        wr(0, 0, 1, 1, "b", 2, 0, "R11");
        wr(0, 1, 1, 2, "c", 3, 0, "R11");
        wr(2, 0, 0, 2, 0,  0, 5, "R11");
        wr(2, 0, 0, 3, 0,  0, 7, "R11");
        wr(2, 0, 0, 4, 0,  0, 3, "R11");
        // duplicate keys for priority checks
        wr(0, 5, 1, 1, "x", 3, 0, "R5");
        wr(0, 6, 1, 1, "x", 4, 0, "R5");
        wr(1, 2, 1, 0, "z", 4, 0, "R6");
        wr(1, 7, 1, 0, "z", 2, 0, "R6");

        tok("ab",  "R5");                      // trans beats default 'b' -> 5
        tok("abc", "R4");                      // 7
        tok("b",   "R3");                      // single-char token -> 3
        tok("ax",  "R5");                      // lowest trans index -> 7
        tok("z",   "R6");                      // lowest default index -> 3
        tok("abx", "R10");                     // ends non-accepting
        tok("abq", "R7");                      // no rule -> idle

        step("a", 0, 0, "R2"); step("b", 0, 1, "R2"); step(8'h20, 0, 0, "R2");

        tok("ab", "R8"); tok("c", "R8");       // second token must start from idle

        step("a", 1, 0, "R12"); step("b", 0, 0, "R12");
        step("c", 1, 1, "R12"); step(8'h20, 0, 0, "R12");

        // writes during a token are ignored
        cfg_we = 1; cfg_tbl = 2; cfg_state = 1; cfg_id = 9;
        step("a", 1, 0, "R11");
        cfg_we = 1; cfg_tbl = 2; cfg_state = 1; cfg_id = 9;
        step("q", 0, 1, "R11"); step(8'h20, 0, 0, "R11");
        tok("a", "R11");
        wr(3, 0, 1, 1, "a", 9, 9, "R11");      // select 3: nothing
        tok("a", "R11");
        wr(2, 0, 0, 1, 0, 0, 9, "R11");
        tok("a", "R11");                       // now 9
        wr(1, 9, 1, 0, "q", 1, 0, "R11");      // default index out of range
        tok("q", "R11");

        for (int n = 0; n < 3000; n++) begin
            byte cs [6] = '{"a", "b", "c", "x", "z", "q"};
            int  r = $urandom % 8;
            step(cs[$urandom % 6], r == 0, r < 3, "R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule